// File: doc/BRIEF.md
# Multi-decoder host-to-device address translator

This block holds a small bank of up to four address decoders for a memory-expansion device. Each decoder maps a window of host physical address space onto device physical address space. Software programs each decoder through a 32-bit word-addressed register port. A decoder's values are its window start, its window length, a device-side gap placed in front of it, and a control word. The control word holds the interleave granularity, the interleave ways and a commit request. Writing the control word commits or uncommits that decoder.

A lookup port accepts one host address per cycle. Two cycles later it returns a hit flag and the translated device address. On acceptance, the lookup copies the register bank, and the walk runs only on that copy. The walk visits the decoders in index order and keeps a running device base. A decoder that does not claim the address still adds its share of device space to that running base. On a hit, the interleave-way bits just above the granule are removed from the middle of the window offset.

Top module: `hpa_dpa_xlate`

## Requirements
- R1: After reset every register reads zero, no decoder is committed, `resp_valid` and `resp_hit` are low, and `req_ready` is high.
- R2: The capability word is at word address 0, and its count field is bits [1:0]. Decoder i occupies words 4+8i to 4+8i+6, in this order: start low, start high, length low, length high, control, gap low, gap high. Only bits [31:28] of a low word are stored, and the other bits of a low word read back as zero.
- R3: In the control word, ig is bits [3:0], iw is bits [7:4], the commit request is bit 9, the committed flag is bit 10 and the error flag is bit 11. A control write stores ig, iw and the commit request. It sets committed equal to bit 9 of the written value and clears the error flag. Bits 8 and 11 of a write are ignored.
- R4: The count field selects how many decoders the walk visits: 0 selects 1 decoder, 1 selects 2, and 2 or 3 select 4. Decoders beyond that count are never visited.
- R5: The walk starts from a running device base of zero. It visits decoders in ascending index. Each visited decoder adds its gap to the running base before its range test.
- R6: If the walk reaches a decoder that is not committed, the lookup ends as a miss, even when a later decoder covers the address.
- R7: A committed decoder does not claim the address when the address is below its start, or when (address − start) ≥ length. In that case length >> w is added to the running base, where w is the effective way exponent, and the walk goes on.
- R8: On a claim, with offset = address − start and g = 8 + ig, the result is: running base + (offset mod 2^g) + ((offset >> (g + w)) << g). `resp_hit` is 1.
- R9: iw values 0 to 4 give w = iw (1 to 16 ways). Any other iw value gives w = 0, both in the bit removal and in the running-base step.
- R10: A walk that ends without a claim returns `resp_hit` = 0 and `resp_dpa` = 0.
- R11: A request is accepted on every clock edge where `req_valid` is high. Its result is valid exactly two edges later. Back-to-back requests give back-to-back responses in order.
- R12: A lookup uses the register contents as they were just before its acceptance edge. A register write on that same edge affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request ready |
| req_hpa | input | 64 | Host physical address to translate |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Address claimed by a decoder |
| resp_dpa | output | 64 | Translated device physical address |

## Verification
A register write and a lookup acceptance can fall on the same clock edge. The test that matters is whether the lookup sees the old or the new decoder state. The bench commits a decoder and then drives two things in one cycle: a lookup into that decoder's window, and a control write that uncommits it. That lookup must still hit at the old translation, and a lookup issued right after must miss. The rest of the bench sweeps host addresses across every decoder window and gap. It covers all count encodings, all iw values including one illegal value, several granularities, and a bank with a hole in it. Each expected result comes from the bench's own arithmetic, using division and modulo.

// File: rtl/hpax_pkg.sv
package hpax_pkg;
    localparam int ADDR_W   = 64;
    localparam int ALIGN    = 28;
    localparam int HI_W     = ADDR_W - ALIGN;
    localparam int LO_KEEP  = 32 - ALIGN;
    localparam int GRAN_MIN = 8;
    localparam int MAX_WAYS_EXP = 4;

    localparam int FLD_BASE_LO = 0;
    localparam int FLD_BASE_HI = 1;
    localparam int FLD_SIZE_LO = 2;
    localparam int FLD_SIZE_HI = 3;
    localparam int FLD_CTRL    = 4;
    localparam int FLD_SKIP_LO = 5;
    localparam int FLD_SKIP_HI = 6;

    localparam int CTRL_COMMIT_BIT = 9;

    typedef struct packed {
        logic [HI_W-1:0] base;
        logic [HI_W-1:0] size;
        logic [HI_W-1:0] skip;
        logic [3:0]      ig;
        logic [3:0]      iw;
        logic            commit;
        logic            committed;
    } dec_t;
endpackage

// File: rtl/hpax_regs.sv
module hpax_regs
    import hpax_pkg::*;
#(
    parameter int NUM_DEC    = 4,
    parameter int REG_AW     = 6,
    parameter int DEC_BASE   = 4,
    parameter int DEC_STRIDE = 8,
    parameter int CNT_W      = $clog2(NUM_DEC + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [REG_AW-1:0]       addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    output dec_t [NUM_DEC-1:0]      dec_o,
    output logic [CNT_W-1:0]        cnt_o
);
    localparam int FLD_W = $clog2(DEC_STRIDE);

    typedef struct packed {
        dec_t [NUM_DEC-1:0] dec;
        logic [1:0]         cap;
    } rs_t;

    rs_t s_d, s_q;

    always_comb begin
        logic [REG_AW-1:0] bw;
        logic [REG_AW-1:0] rel;
        logic [FLD_W-1:0]  fld;
        s_d   = s_q;
        rdata = '0;
        if (addr == '0) begin
            rdata = {30'b0, s_q.cap};
            if (we) s_d.cap = wdata[1:0];
        end
        for (int i = 0; i < NUM_DEC; i++) begin
            bw  = REG_AW'(DEC_BASE + i * DEC_STRIDE);
            rel = addr - bw;
            fld = rel[FLD_W-1:0];
            if (addr >= bw && rel < REG_AW'(DEC_STRIDE)) begin
                case (int'(fld))
                    FLD_BASE_LO: begin
                        rdata = {s_q.dec[i].base[LO_KEEP-1:0], {ALIGN{1'b0}}};
                        if (we) s_d.dec[i].base[LO_KEEP-1:0] = wdata[31:ALIGN];
                    end
                    FLD_BASE_HI: begin
                        rdata = s_q.dec[i].base[HI_W-1:LO_KEEP];
                        if (we) s_d.dec[i].base[HI_W-1:LO_KEEP] = wdata;
                    end
                    FLD_SIZE_LO: begin
                        rdata = {s_q.dec[i].size[LO_KEEP-1:0], {ALIGN{1'b0}}};
                        if (we) s_d.dec[i].size[LO_KEEP-1:0] = wdata[31:ALIGN];
                    end
                    FLD_SIZE_HI: begin
                        rdata = s_q.dec[i].size[HI_W-1:LO_KEEP];
                        if (we) s_d.dec[i].size[HI_W-1:LO_KEEP] = wdata;
                    end
                    FLD_SKIP_LO: begin
                        rdata = {s_q.dec[i].skip[LO_KEEP-1:0], {ALIGN{1'b0}}};
                        if (we) s_d.dec[i].skip[LO_KEEP-1:0] = wdata[31:ALIGN];
                    end
                    FLD_SKIP_HI: begin
                        rdata = s_q.dec[i].skip[HI_W-1:LO_KEEP];
                        if (we) s_d.dec[i].skip[HI_W-1:LO_KEEP] = wdata;
                    end
                    FLD_CTRL: begin
                        rdata = {20'b0, 1'b0, s_q.dec[i].committed, s_q.dec[i].commit,
                                 1'b0, s_q.dec[i].iw, s_q.dec[i].ig};
                        if (we) begin
                            s_d.dec[i].ig        = wdata[3:0];
                            s_d.dec[i].iw        = wdata[7:4];
                            s_d.dec[i].commit    = wdata[CTRL_COMMIT_BIT];
                            s_d.dec[i].committed = wdata[CTRL_COMMIT_BIT];
                        end
                    end
                    default: rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        int n;
        case (s_q.cap)
            2'd0:    n = 1;
            2'd1:    n = 2;
            default: n = 4;
        endcase
        if (n > NUM_DEC) n = NUM_DEC;
        cnt_o = CNT_W'(n);
    end

    assign dec_o = s_q.dec;
endmodule

// File: rtl/hpax_walk.sv
module hpax_walk
    import hpax_pkg::*;
#(
    parameter int NUM_DEC = 4,
    parameter int CNT_W   = $clog2(NUM_DEC + 1)
) (
    input  dec_t [NUM_DEC-1:0]  dec_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [ADDR_W-1:0]   hpa_i,
    output logic                hit_o,
    output logic [ADDR_W-1:0]   dpa_o
);
    always_comb begin
        logic [ADDR_W-1:0] run, base, size, skip, off, low, high;
        logic              done;
        int                g, w;
        run   = '0;
        done  = 1'b0;
        hit_o = 1'b0;
        dpa_o = '0;
        for (int i = 0; i < NUM_DEC; i++) begin
            base = {dec_i[i].base, {ALIGN{1'b0}}};
            size = {dec_i[i].size, {ALIGN{1'b0}}};
            skip = {dec_i[i].skip, {ALIGN{1'b0}}};
            w    = (int'(dec_i[i].iw) <= MAX_WAYS_EXP) ? int'(dec_i[i].iw) : 0;
            g    = GRAN_MIN + int'(dec_i[i].ig);
            off  = hpa_i - base;
            low  = off & ((ADDR_W'(1) << g) - ADDR_W'(1));
            high = (off >> (g + w)) << g;
            if (!done && i < int'(cnt_i)) begin
                run = run + skip;
                if (!dec_i[i].committed) begin
                    done = 1'b1;
                end else if (hpa_i >= base && off < size) begin
                    done  = 1'b1;
                    hit_o = 1'b1;
                    dpa_o = run + (low | high);
                end else begin
                    run = run + (size >> w);
                end
            end
        end
    end
endmodule

// File: rtl/hpa_dpa_xlate.sv
module hpa_dpa_xlate
    import hpax_pkg::*;
#(
    parameter int NUM_DEC    = 4,
    parameter int REG_AW     = 6,
    parameter int DEC_BASE   = 4,
    parameter int DEC_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_hpa,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [63:0]       resp_dpa
);
    localparam int CNT_W = $clog2(NUM_DEC + 1);

    typedef struct packed {
        logic               s1_v;
        logic [ADDR_W-1:0]  s1_hpa;
        dec_t [NUM_DEC-1:0] s1_dec;
        logic [CNT_W-1:0]   s1_cnt;
        logic               r_v;
        logic               r_hit;
        logic [ADDR_W-1:0]  r_dpa;
    } pipe_t;

    dec_t [NUM_DEC-1:0] dec_w;
    logic [CNT_W-1:0]   cnt_w;
    logic               w_hit;
    logic [ADDR_W-1:0]  w_dpa;
    logic [NUM_DEC-1:0] committed_vec;
    pipe_t              p_d, p_q;

    hpax_regs #(
        .NUM_DEC(NUM_DEC), .REG_AW(REG_AW), .DEC_BASE(DEC_BASE),
        .DEC_STRIDE(DEC_STRIDE), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .dec_o(dec_w), .cnt_o(cnt_w)
    );

    hpax_walk #(.NUM_DEC(NUM_DEC), .CNT_W(CNT_W)) u_walk (
        .dec_i(p_q.s1_dec), .cnt_i(p_q.s1_cnt), .hpa_i(p_q.s1_hpa),
        .hit_o(w_hit), .dpa_o(w_dpa)
    );

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_cv
        assign committed_vec[i] = dec_w[i].committed;
    end

    assign req_ready = 1'b1;

    always_comb begin
        p_d      = p_q;
        p_d.s1_v = req_valid && req_ready;
        if (req_valid && req_ready) begin
            p_d.s1_hpa = req_hpa;
            p_d.s1_dec = dec_w;
            p_d.s1_cnt = cnt_w;
        end
        p_d.r_v   = p_q.s1_v;
        p_d.r_hit = p_q.s1_v && w_hit;
        p_d.r_dpa = (p_q.s1_v && w_hit) ? w_dpa : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign resp_valid = p_q.r_v;
    assign resp_hit   = p_q.r_hit;
    assign resp_dpa   = p_q.r_dpa;
endmodule

// File: rtl/hpa_dpa_xlate_chk.sv
module hpa_dpa_xlate_chk #(
    parameter int NUM_DEC    = 4,
    parameter int REG_AW     = 6,
    parameter int DEC_BASE   = 4,
    parameter int DEC_STRIDE = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic [63:0]        resp_dpa,
    input logic [NUM_DEC-1:0] committed
);
    // R11
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid == $past(req_valid && req_ready, 2));

    // R10
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_valid);

    // R10
    miss_dpa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_hit |-> resp_dpa == 64'd0);

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
        localparam logic [REG_AW-1:0] CA = REG_AW'(DEC_BASE + i * DEC_STRIDE + 4);
        // R3
        commit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == CA) |=> committed[i] == $past(reg_wdata[9]));
        // R3
        commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_we && reg_addr == CA) |=> $stable(committed[i]));
    end
endmodule

bind hpa_dpa_xlate hpa_dpa_xlate_chk #(
    .NUM_DEC(NUM_DEC), .REG_AW(REG_AW), .DEC_BASE(DEC_BASE), .DEC_STRIDE(DEC_STRIDE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_dpa(resp_dpa),
    .committed(committed_vec)
);

// File: tb/hpa_dpa_xlate_tb.sv
`timescale 1ns/1ps
module hpa_dpa_xlate_tb;
    localparam logic [63:0] U = 64'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_hpa = '0;
    logic        resp_valid, resp_hit;
    logic [63:0] resp_dpa;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [63:0] m_base [4];
    logic [63:0] m_size [4];
    logic [63:0] m_skip [4];
    int          m_ig [4];
    int          m_iw [4];
    bit          m_com [4];
    int          m_cap = 0;

    always #4 clk = ~clk;

    hpa_dpa_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_hpa(req_hpa), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_dpa(resp_dpa)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 6'(a);
        #1 d = reg_rdata;
    endtask

    function automatic int ctrl_addr(input int i);
        return 4 + 8 * i + 4;
    endfunction

    task automatic prog(input int i, input logic [63:0] b, input logic [63:0] s, input logic [63:0] k);
        wr(4 + 8 * i + 0, b[31:0]);  wr(4 + 8 * i + 1, b[63:32]);
        wr(4 + 8 * i + 2, s[31:0]);  wr(4 + 8 * i + 3, s[63:32]);
        wr(4 + 8 * i + 5, k[31:0]);  wr(4 + 8 * i + 6, k[63:32]);
        m_base[i] = b; m_size[i] = s; m_skip[i] = k;
    endtask

    task automatic set_ctrl(input int i, input int ig, input int iw, input bit c);
        wr(ctrl_addr(i), 32'((c ? 512 : 0) + iw * 16 + ig));
        m_ig[i] = ig; m_iw[i] = iw; m_com[i] = c;
    endtask

    task automatic set_cap(input int v);
        wr(0, 32'(v));
        m_cap = v;
    endtask

    function automatic void model(input logic [63:0] h, output logic hit, output logic [63:0] dpa);
        logic [63:0] run, off, gs;
        int n, w;
        run = 0; hit = 0; dpa = 0;
        n = (m_cap == 0) ? 1 : (m_cap == 1) ? 2 : 4;
        for (int i = 0; i < n; i++) begin
            run = run + m_skip[i];
            if (!m_com[i]) return;
            w = (m_iw[i] <= 4) ? m_iw[i] : 0;
            if (h >= m_base[i] && (h - m_base[i]) < m_size[i]) begin
                off = h - m_base[i];
                gs  = 64'd1 << (8 + m_ig[i]);
                dpa = run + (off % gs) + ((off / (gs << w)) * gs);
                hit = 1;
                return;
            end
            run = run + m_size[i] / (64'd1 << w);
        end
    endfunction

    task automatic lookup(input string tag, input logic [63:0] h);
        logic        eh;
        logic [63:0] ed;
        model(h, eh, ed);
        @(negedge clk);
        req_valid = 1'b1; req_hpa = h;
        @(negedge clk);
        req_valid = 1'b0;
        check({"R11 early ", tag}, 64'(resp_valid), 64'd0);
        @(negedge clk);
        check({"R11 valid ", tag}, 64'(resp_valid), 64'd1);
        check({"hit ", tag}, 64'(resp_hit), 64'(eh));
        check({"dpa ", tag}, resp_dpa, ed);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R11 actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] offs [3];
        offs[0] = 64'h0; offs[1] = 64'h2345; offs[2] = 64'h0ABC_DEF0;
        for (int i = 0; i < 4; i++) begin
            m_base[i] = 0; m_size[i] = 0; m_skip[i] = 0; m_ig[i] = 0; m_iw[i] = 0; m_com[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 resp_valid", 64'(resp_valid), 0);
        check("R1 resp_hit", 64'(resp_hit), 0);
        check("R1 req_ready", 64'(req_ready), 1);
        rd(0, d);            check("R1 cap", 64'(d), 0);
        rd(ctrl_addr(2), d); check("R1 ctrl2", 64'(d), 0);
        rd(4 + 8 * 3 + 1, d); check("R1 base_hi3", 64'(d), 0);
        lookup("R1 R6 miss after reset", 64'h0);

        // R2 low word keeps only [31:28]
        wr(4 + 8 * 1 + 2, 32'hFFFF_FFFF);
        rd(4 + 8 * 1 + 2, d); check("R2 size_lo", 64'(d), 64'hF000_0000);
        wr(4 + 8 * 2 + 6, 32'h1234_5678);
        rd(4 + 8 * 2 + 6, d); check("R2 skip_hi", 64'(d), 64'h1234_5678);
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); check("R2 cap", 64'(d), 3);

        // R3 control word fields
        wr(ctrl_addr(0), 32'h0000_0FFF);
        rd(ctrl_addr(0), d); check("R3 commit set", 64'(d), 64'h6FF);
        wr(ctrl_addr(0), 32'h0000_0800);
        rd(ctrl_addr(0), d); check("R3 uncommit", 64'(d), 0);

        // bank: decoder windows, gaps
        prog(0, 2 * U, 2 * U, 1 * U);
        prog(1, 6 * U, 4 * U, 0);
        prog(2, 4 * U, 1 * U, 2 * U);
        prog(3, 12 * U, 2 * U, 1 * U);

        // R4 R5 R6 R7 R8 R9 R10 sweep
        for (int ce = 0; ce < 4; ce++) begin
            set_cap(ce);
            for (int iwv = 0; iwv < 6; iwv++) begin
                for (int k = 0; k < 3; k++) begin
                    for (int cm = 0; cm < 2; cm++) begin
                        for (int i = 0; i < 4; i++)
                            set_ctrl(i, k * 2 + k / 2 + i, (iwv + i) % 6, !(cm == 1 && i == 1));
                        for (int u = 0; u < 16; u++)
                            for (int o = 0; o < 3; o++)
                                lookup("R4 R5 R6 R7 R8 R9 R10", 64'(u) * U + offs[o]);
                    end
                end
            end
        end

        // R9 illegal iw value 15
        set_cap(2);
        for (int i = 0; i < 4; i++) set_ctrl(i, 1, 15, 1);
        lookup("R9 iw15 d1", 7 * U + 64'h1357);
        lookup("R9 iw15 d3", 13 * U + 64'h0F00_0000);

        // R11 back-to-back
        for (int i = 0; i < 4; i++) set_ctrl(i, 0, 1, 1);
        begin
            logic eh [3];
            logic [63:0] ed [3];
            logic [63:0] hs [3];
            hs[0] = 2 * U + 64'h300; hs[1] = 7 * U + 64'h4400; hs[2] = 1 * U;
            for (int j = 0; j < 3; j++) model(hs[j], eh[j], ed[j]);
            @(negedge clk); req_valid = 1; req_hpa = hs[0];
            @(negedge clk); req_hpa = hs[1];
            check("R11 b2b gap", 64'(resp_valid), 0);
            @(negedge clk); req_hpa = hs[2];
            check("R11 b2b v0", 64'(resp_valid), 1);
            check("R11 b2b d0", resp_dpa, ed[0]);
            @(negedge clk); req_valid = 0;
            check("R11 b2b h1", 64'(resp_hit), 64'(eh[1]));
            check("R11 b2b d1", resp_dpa, ed[1]);
            @(negedge clk);
            check("R11 b2b v2", 64'(resp_valid), 1);
            check("R11 b2b h2", 64'(resp_hit), 64'(eh[2]));
            @(negedge clk);
            check("R11 b2b idle", 64'(resp_valid), 0);
        end

        // R12 write and accept on the same edge
        set_cap(0);
        set_ctrl(0, 0, 0, 1);
        @(negedge clk);
        req_valid = 1; req_hpa = 3 * U + 64'h77;
        reg_we = 1; reg_addr = 6'(ctrl_addr(0)); reg_wdata = 32'h0;
        @(negedge clk);
        req_valid = 0; reg_we = 0;
        @(negedge clk);
        check("R12 old state hit", 64'(resp_hit), 1);
        check("R12 old state dpa", resp_dpa, 1 * U + 1 * U + 64'h77);
        m_com[0] = 0;
        lookup("R12 new state", 3 * U + 64'h77);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule